// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt request lines from two 32-bit source banks and settles them into a single request to the processor, together with the number of the source that should be serviced. Each source is gated by a per-source enable bit. Software can also raise any source through a per-source force bit. The pending and enabled sources are arbitrated, and the winner's number is registered into a vector that software reads to find out what to service.

Bank 0 carries sources 32 to 63: bank bit n is source 32+n. It is split into four priority groups of eight sources, and group g covers bits 8g to 8g+7. Each group has an ordering register. That register holds eight 3-bit slots, and each slot names a member of the group by its index 0 to 7. Bank 1 carries sources 64 to 95: bank bit n is source 64+n. Bank 1 sources belong to no group. A configuration field names one source that outranks every other. All registers sit on a plain 32-bit word-addressed bus with a one-cycle write strobe and a combinational read port.

Top module: `vec_prio_intc`

## Requirements
- R1: After reset, both enable registers and both force registers read 0, the vector reads 0 and `irq_o` is low. Each ordering register reads its identity value, in which slot p holds p (0x05309770).
- R2: Source bit n of a bank is enabled by bit (31-n) of that bank's enable register (address 0 for bank 0, address 1 for bank 1). A 1 enables the source. A disabled source never wins.
- R3: Bit (31-n) of a bank's force register (address 2 for bank 0, address 3 for bank 1) makes source bit n pending while it is 1, exactly as if the line were high. Writing 0 withdraws it. The register reads back what was written.
- R4: The ordering register of group g is at address 4+g. Slot position p in 0..3 occupies bits [22+(3-p)*3 : 20+(3-p)*3]. Slot position p in 4..7 occupies bits [6+(7-p)*3 : 4+(7-p)*3]. Among grouped sources, the one named by a lower slot position wins.
- R5: When two groups offer a candidate at the same slot position, the lower-numbered group wins.
- R6: Bits 30:24 of the configuration register (address 8) name a source. If that source is pending and enabled, it wins over every other source.
- R7: An active source that no slot names, and every bank 1 source, ranks below all grouped candidates. Among these, the lowest source number wins.
- R8: The vector (address 9) returns the winning source number in bits 6:0 and 0 in all other bits. It returns 0 when nothing is active. `irq_o` is high exactly when the vector is nonzero. Both reflect the sources and registers as they stood at the previous rising clock edge.
- R9: Reads from addresses 10 to 15 return 0, and writes to them change nothing. A write to the vector address is ignored.
- R10: Bits outside the defined fields read 0: bits 19:16 and 3:0 of an ordering register, and all bits of the configuration register except 30:24. A field naming a source number that does not exist never wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_bank0_i | input | 32 | Request lines of sources 32..63, active high |
| src_bank1_i | input | 32 | Request lines of sources 64..95, active high |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench checks the bit reversal between a source's bank position and its enable and force bits. A design that used the plain bit order would enable or raise the wrong source and report a different vector. It sets up ties at the same slot position in two groups, and ties between slot positions inside one group. A scan that ran groups in the outer loop, or read the slot bits at a shifted offset, would return a different source number. It points the top-priority field at a bank 1 source, then masks that source, and finally points the field at a nonexistent number. This catches a design that lets a disabled or imaginary source win. It also measures the one-cycle latency from a request line to `irq_o`, and checks that unmapped addresses and the read-only vector absorb writes.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int BANK_W   = 32;
  localparam int SLOT_W   = 3;
  localparam int GRP_SIZE = 8;
  localparam int VEC_W    = 7;
  localparam int ADDR_W   = 4;
  localparam int HPI_LSB  = 24;

  localparam logic [ADDR_W-1:0] A_EN0    = 4'd0;
  localparam logic [ADDR_W-1:0] A_EN1    = 4'd1;
  localparam logic [ADDR_W-1:0] A_FRC0   = 4'd2;
  localparam logic [ADDR_W-1:0] A_FRC1   = 4'd3;
  localparam logic [ADDR_W-1:0] A_ORD0   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CFG    = 4'd8;
  localparam logic [ADDR_W-1:0] A_VEC    = 4'd9;
  localparam logic [ADDR_W-1:0] A_UNMAP  = 4'd10;

  localparam logic [BANK_W-1:0] HPI_FIELD = 32'h7F00_0000;

  // lowest bit of the slot that holds slot position p
  function automatic int slot_lsb(input int p);
    return (p < 4) ? 20 + (3 - p) * 3 : 4 + (7 - p) * 3;
  endfunction

  function automatic logic [BANK_W-1:0] ord_field_mask();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int p = 0; p < GRP_SIZE; p++) m[slot_lsb(p) +: SLOT_W] = '1;
    return m;
  endfunction

  function automatic logic [BANK_W-1:0] ord_identity();
    logic [BANK_W-1:0] v;
    v = '0;
    for (int p = 0; p < GRP_SIZE; p++) v[slot_lsb(p) +: SLOT_W] = SLOT_W'(p);
    return v;
  endfunction
endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [BANK_W-1:0]                   wdata_i,
  output logic [BANK_W-1:0]                   rdata_o,
  input  logic [VEC_W-1:0]                    vec_i,
  output logic [BANK_W-1:0]                   en0_o,
  output logic [BANK_W-1:0]                   en1_o,
  output logic [BANK_W-1:0]                   frc0_o,
  output logic [BANK_W-1:0]                   frc1_o,
  output logic [NUM_GROUPS-1:0][BANK_W-1:0]   ord_o,
  output logic [VEC_W-1:0]                    hpi_o
);
  localparam logic [BANK_W-1:0] ORD_MASK = ord_field_mask();
  localparam logic [BANK_W-1:0] ORD_RST  = ord_identity();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en0_o  <= '0;
      en1_o  <= '0;
      frc0_o <= '0;
      frc1_o <= '0;
      hpi_o  <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_EN0:   en0_o  <= wdata_i;
        A_EN1:   en1_o  <= wdata_i;
        A_FRC0:  frc0_o <= wdata_i;
        A_FRC1:  frc1_o <= wdata_i;
        A_CFG:   hpi_o  <= wdata_i[HPI_LSB +: VEC_W];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_ord
    localparam logic [ADDR_W-1:0] MY_ADDR = A_ORD0 + ADDR_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ord_o[g] <= ORD_RST;
      else if (we_i && addr_i == MY_ADDR)  ord_o[g] <= wdata_i & ORD_MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_EN0:  rdata_o = en0_o;
      A_EN1:  rdata_o = en1_o;
      A_FRC0: rdata_o = frc0_o;
      A_FRC1: rdata_o = frc1_o;
      A_CFG:  rdata_o[HPI_LSB +: VEC_W] = hpi_o;
      A_VEC:  rdata_o[VEC_W-1:0] = vec_i;
      default: begin
        for (int g = 0; g < NUM_GROUPS; g++)
          if (addr_i == A_ORD0 + ADDR_W'(g)) rdata_o = ord_o[g];
      end
    endcase
  end
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb
  import vpic_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int BANK0_BASE = 32,
  parameter int BANK1_BASE = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [BANK_W-1:0]                 src0_i,
  input  logic [BANK_W-1:0]                 src1_i,
  input  logic [BANK_W-1:0]                 en0_i,
  input  logic [BANK_W-1:0]                 en1_i,
  input  logic [BANK_W-1:0]                 frc0_i,
  input  logic [BANK_W-1:0]                 frc1_i,
  input  logic [NUM_GROUPS-1:0][BANK_W-1:0] ord_i,
  input  logic [VEC_W-1:0]                  hpi_i,
  output logic [VEC_W-1:0]                  vec_o
);
  localparam int IDX_W = $clog2(BANK_W);

  logic [BANK_W-1:0] act0, act1;
  logic [VEC_W-1:0]  win;
  logic              found;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  idx;
  int                h;

  // control bits are stored mirrored: bank bit n uses control bit 31-n
  for (genvar n = 0; n < BANK_W; n++) begin : g_act
    assign act0[n] = (src0_i[n] | frc0_i[BANK_W-1-n]) & en0_i[BANK_W-1-n];
    assign act1[n] = (src1_i[n] | frc1_i[BANK_W-1-n]) & en1_i[BANK_W-1-n];
  end

  always_comb begin
    win   = '0;
    found = 1'b0;
    slot  = '0;
    idx   = '0;
    h     = int'(hpi_i);
    // top-priority source first
    if (h >= BANK0_BASE && h < BANK0_BASE + BANK_W) begin
      idx = IDX_W'(h - BANK0_BASE);
      if (act0[idx]) begin win = hpi_i; found = 1'b1; end
    end else if (h >= BANK1_BASE && h < BANK1_BASE + BANK_W) begin
      idx = IDX_W'(h - BANK1_BASE);
      if (act1[idx]) begin win = hpi_i; found = 1'b1; end
    end
    // grouped: slot position outer, group number inner
    for (int p = 0; p < GRP_SIZE; p++) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        slot = ord_i[g][slot_lsb(p) +: SLOT_W];
        idx  = IDX_W'(g * GRP_SIZE + int'(slot));
        if (!found && act0[idx]) begin
          win   = VEC_W'(BANK0_BASE + g * GRP_SIZE + int'(slot));
          found = 1'b1;
        end
      end
    end
    // everything else by lowest source number
    for (int n = 0; n < BANK_W; n++) begin
      if (!found && act0[n]) begin win = VEC_W'(BANK0_BASE + n); found = 1'b1; end
    end
    for (int n = 0; n < BANK_W; n++) begin
      if (!found && act1[n]) begin win = VEC_W'(BANK1_BASE + n); found = 1'b1; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_o <= '0;
    else        vec_o <= win;
  end
endmodule

// File: rtl/vec_prio_intc.sv
module vec_prio_intc
  import vpic_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int BANK0_BASE = 32,
  parameter int BANK1_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       src_bank0_i,
  input  logic [31:0]       src_bank1_i,
  input  logic              bus_we_i,
  input  logic [3:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  logic [BANK_W-1:0]                 en0, en1, frc0, frc1;
  logic [NUM_GROUPS-1:0][BANK_W-1:0] ord;
  logic [VEC_W-1:0]                  hpi;
  logic [VEC_W-1:0]                  vec;

  vpic_regs #(.NUM_GROUPS(NUM_GROUPS)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .vec_i(vec),
    .en0_o(en0), .en1_o(en1), .frc0_o(frc0), .frc1_o(frc1),
    .ord_o(ord), .hpi_o(hpi)
  );

  vpic_arb #(
    .NUM_GROUPS(NUM_GROUPS), .BANK0_BASE(BANK0_BASE), .BANK1_BASE(BANK1_BASE)
  ) i_arb (
    .clk(clk), .rst_n(rst_n),
    .src0_i(src_bank0_i), .src1_i(src_bank1_i),
    .en0_i(en0), .en1_i(en1), .frc0_i(frc0), .frc1_i(frc1),
    .ord_i(ord), .hpi_i(hpi), .vec_o(vec)
  );

  assign irq_o = (vec != '0);
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
  import vpic_pkg::*;
#(
  parameter int BANK0_BASE = 32,
  parameter int BANK1_BASE = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BANK_W-1:0] bus_wdata,
  input logic [BANK_W-1:0] bus_rdata,
  input logic              irq,
  input logic [VEC_W-1:0]  vec,
  input logic [BANK_W-1:0] src0,
  input logic [BANK_W-1:0] src1,
  input logic [BANK_W-1:0] en0,
  input logic [BANK_W-1:0] en1,
  input logic [BANK_W-1:0] frc0,
  input logic [BANK_W-1:0] frc1,
  input logic [VEC_W-1:0]  hpi
);
  logic       hpi_act;
  logic [4:0] k;
  int         h;

  always_comb begin
    hpi_act = 1'b0;
    k = '0;
    h = int'(hpi);
    if (h >= BANK0_BASE && h < BANK0_BASE + BANK_W) begin
      k = 5'(h - BANK0_BASE);
      hpi_act = (src0[k] | frc0[~k]) & en0[~k];
    end else if (h >= BANK1_BASE && h < BANK1_BASE + BANK_W) begin
      k = 5'(h - BANK1_BASE);
      hpi_act = (src1[k] | frc1[~k]) & en1[~k];
    end
  end

  // R2: with every source disabled, no request follows
  p_all_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 == '0 && en1 == '0) |=> !irq);

  // R3: a force write lands in the force register
  p_force_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_FRC0) |=> (frc0 == $past(bus_wdata)));

  // R6: an active top-priority source is the next vector
  p_hpi_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hpi_act |=> (vec == $past(hpi)));

  // R8: a request always carries a real source number
  p_irq_valid_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int'(vec) >= BANK0_BASE && int'(vec) < BANK1_BASE + BANK_W));

  // R9: unmapped addresses read zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= A_UNMAP) |-> (bus_rdata == '0));
endmodule

bind vec_prio_intc vpic_chk #(.BANK0_BASE(BANK0_BASE), .BANK1_BASE(BANK1_BASE)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we_i), .bus_addr(bus_addr_i),
  .bus_wdata(bus_wdata_i), .bus_rdata(bus_rdata_o), .irq(irq_o), .vec(vec),
  .src0(src_bank0_i), .src1(src_bank1_i), .en0(en0), .en1(en1),
  .frc0(frc0), .frc1(frc1), .hpi(hpi)
);

// File: tb/test_vec_prio_intc.sv
module test_vec_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src0 = '0, src1 = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  vec_prio_intc i_vec_prio_intc (
    .clk(clk), .rst_n(rst_n), .src_bank0_i(src0), .src_bank1_i(src1),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  // row: src0, src1, enable0 (plain order), enable1 (plain order), expected vector
  localparam int ROWS = 8;
  localparam logic [135:0] TBL [ROWS] = '{
    {32'h0000_0020, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd37}, // R2 single source
    {32'h0000_1008, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd35}, // R4 slot 3 beats slot 4
    {32'h0000_0204, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd41}, // R4 slot 1 in g1 beats slot 2 in g0
    {32'h0000_0101, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd32}, // R5 group 0 first
    {32'h0, 32'h0000_0088, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd67}, // R7 lowest ungrouped
    {32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd63}, // R7 grouped first
    {32'h0000_0020, 32'h0000_0004, 32'hFFFF_FFDF, 32'hFFFF_FFFF, 8'd66}, // R2 masked source loses
    {32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd0}            // R8 nothing pending
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 6:    return "R2";
      1, 2:    return "R4";
      3:       return "R5";
      4, 5:    return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = x[i];
    return r;
  endfunction

  function automatic int lsb_of(input int p);
    return (p < 4) ? 20 + (3 - p) * 3 : 4 + (7 - p) * 3;
  endfunction

  function automatic logic [31:0] ord_val(input logic [2:0] s [8]);
    logic [31:0] v;
    v = '0;
    for (int p = 0; p < 8; p++) v[lsb_of(p) +: 3] = s[p];
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] ident;
    logic [2:0]  sl [8];
    for (int p = 0; p < 8; p++) sl[p] = 3'(p);
    ident = ord_val(sl);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, d); check("R1 enable0", d, 32'h0);
    rd(4'd1, d); check("R1 enable1", d, 32'h0);
    rd(4'd2, d); check("R1 force0", d, 32'h0);
    rd(4'd3, d); check("R1 force1", d, 32'h0);
    for (int g = 0; g < 4; g++) begin
      rd(4'(4 + g), d); check("R1 order reg", d, ident);
    end
    check("R1 identity constant", ident, 32'h0530_9770);
    rd(4'd9, d); check("R1 vector", d, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // table walk
    for (int i = 0; i < ROWS; i++) begin
      wr(4'd0, rev(TBL[i][71:40]));
      wr(4'd1, rev(TBL[i][39:8]));
      src0 = TBL[i][135:104];
      src1 = TBL[i][103:72];
      settle();
      rd(4'd9, d); check({row_tag(i), " table vector"}, d, {24'h0, TBL[i][7:0]});
      check({row_tag(i), " table irq R8"}, {31'h0, irq}, {31'h0, TBL[i][7:0] != 8'd0});
    end

    src0 = '0; src1 = '0;
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);

    // R3 force bits
    wr(4'd2, rev(32'h10));
    settle();
    rd(4'd9, d); check("R3 force bank0 vector", d, 32'd36);
    rd(4'd2, d); check("R3 force readback", d, rev(32'h10));
    wr(4'd2, 32'h0);
    settle();
    rd(4'd9, d); check("R3 force withdrawn", d, 32'd0);
    wr(4'd3, rev(32'h200));
    settle();
    rd(4'd9, d); check("R3 force bank1 vector", d, 32'd73);
    wr(4'd3, 32'h0);

    // R4 reprogrammed order in group 0: slot 0 names 5, slot 5 names 0
    sl[0] = 3'd5; sl[5] = 3'd0;
    wr(4'd4, ord_val(sl));
    src0 = 32'h21;
    settle();
    rd(4'd9, d); check("R4 reordered winner", d, 32'd37);
    src0 = 32'h01;
    settle();
    rd(4'd9, d); check("R4 moved source still served", d, 32'd32);
    sl[0] = 3'd0; sl[5] = 3'd5;
    wr(4'd4, ident);

    // R6 top-priority source
    wr(4'd8, 32'd70 << 24);
    rd(4'd8, d); check("R6 config readback", d, 32'd70 << 24);
    src0 = 32'h01; src1 = 32'h40;
    settle();
    rd(4'd9, d); check("R6 top source wins", d, 32'd70);
    wr(4'd1, ~rev(32'h40));
    settle();
    rd(4'd9, d); check("R6 masked top source loses", d, 32'd32);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd8, 32'h0);
    src0 = '0; src1 = '0;
    settle();

    // R8 one-cycle latency
    rd(4'd9, d); check("R8 idle vector", d, 32'd0);
    src0 = 32'h08;
    #1;
    check("R8 irq before edge", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq after one edge", {31'h0, irq}, 32'h1);
    rd(4'd9, d); check("R8 vector after one edge", d, 32'd35);

    // R9 unmapped and read-only addresses
    wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd12, d); check("R9 unmapped read", d, 32'h0);
    rd(4'd15, d); check("R9 unmapped read top", d, 32'h0);
    wr(4'd9, 32'h55);
    settle();
    rd(4'd9, d); check("R9 vector write ignored", d, 32'd35);
    rd(4'd0, d); check("R9 enable untouched", d, 32'hFFFF_FFFF);

    // R10 reserved bits and nonexistent top source
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, d); check("R10 order reg reserved bits", d, 32'hFFF0_FFF0);
    wr(4'd5, ident);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, d); check("R10 config reserved bits", d, 32'h7F00_0000);
    settle();
    rd(4'd9, d); check("R10 nonexistent top source", d, 32'd35);
    wr(4'd8, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule